// File: doc/BRIEF.md
# 4b/5b Symbol Encoder with NRZI Line Output

This block takes a stream of 4-bit nibbles over a valid/ready handshake. Each nibble carries a tag that marks it as plain data or as the escape code. Every nibble becomes a 5-bit symbol from a fixed 17-entry code: sixteen data symbols plus one escape symbol. The symbol is shifted onto a single line, most significant bit first, one bit per clock. The line is NRZI coded: a 1 bit flips the line level and a 0 bit leaves it unchanged.

The upstream source supplies one nibble every five clocks to keep the line busy. If no nibble is ready when a symbol's last bit goes out, the serializer goes idle and the line holds its level. A one-cycle underrun flag reports the gap. Scrambling happens upstream of this block.

Top module: `nrzi_4b5b_tx`

## Requirements
- R1: While reset is held and just after it is released, `line_out` is 0, `in_ready` is 1 and `underrun_err` is 0.
- R2: A data nibble (`in_is_esc`=0) maps to a symbol as follows: 0→10101, 1→01001, 2→01010, 3→01011, 4→00111, 5→01101, 6→01110, 7→01111, 8→10010, 9→11001, A→11010, B→11011, C→10111, D→11101, E→11110, F→11111.
- R3: A nibble tagged as escape (`in_is_esc`=1) is sent as symbol 00010, whatever the value on `in_nibble`.
- R4: Each symbol takes exactly five clocks on the line and is sent bit 4 first, bit 0 last.
- R5: The line level changes only for a 1 bit. Each 1 bit inverts `line_out` and each 0 bit leaves it unchanged. Bit 4 of a symbol accepted at edge E0 shows on `line_out` after edge E0+1, and bit 4-k shows after edge E0+1+k. When no symbol is being sent, the line holds its level.
- R6: `in_ready` is 1 when the block is idle and during the last bit of a symbol, and 0 at all other times. A source that holds `in_valid` high therefore gets one nibble accepted every five clocks, with no gap between symbols.
- R7: If a symbol's last bit is going out and `in_valid` is 0, the block becomes idle and `underrun_err` is 1 for exactly the cycle that follows that edge. Idle time before the first nibble, or after an underrun, raises no further flag.
- R8: During back-to-back transmission, `line_out` never keeps the same level for more than five consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A nibble is offered |
| in_ready | output | 1 | The offered nibble is taken at this edge |
| in_nibble | input | 4 | Nibble value |
| in_is_esc | input | 1 | 1 = send the escape symbol instead of data |
| line_out | output | 1 | NRZI-coded serial line |
| underrun_err | output | 1 | One-cycle pulse when the input ran dry at a symbol boundary |

## Verification
Two things can happen at the same edge: the last bit of one symbol is shifted out, and either the next nibble is loaded or an underrun is detected. The bench sets up both cases. In one, it holds `in_valid` high through long bursts so that every load lands on the same edge as the final bit of the previous symbol. In the other, it drops `in_valid` for one or more symbols so that the final bit coincides with the underrun decision. A behavioural model built from queues is compared with the line, the ready signal and the flag on every clock. The serial symbols are also rebuilt from the line transitions and compared with the code table.

// File: rtl/tx4b5b_pkg.sv
// Shared widths, the escape code and the nibble-to-symbol map.
// Assumes a fixed 4-bit nibble and 5-bit symbol code.
package tx4b5b_pkg;
    localparam int NIB_W = 4;
    localparam int SYM_W = 5;
    localparam int CNT_W = $clog2(SYM_W);

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [SYM_W-1:0] sym_t;

    localparam sym_t ESC_SYM = 5'b00010;

    // Data nibble to line symbol.
    function automatic sym_t data_symbol(input nib_t n);
        sym_t s;
        case (n)
            4'h0: s = 5'b10101;
            4'h1: s = 5'b01001;
            4'h2: s = 5'b01010;
            4'h3: s = 5'b01011;
            4'h4: s = 5'b00111;
            4'h5: s = 5'b01101;
            4'h6: s = 5'b01110;
            4'h7: s = 5'b01111;
            4'h8: s = 5'b10010;
            4'h9: s = 5'b11001;
            4'hA: s = 5'b11010;
            4'hB: s = 5'b11011;
            4'hC: s = 5'b10111;
            4'hD: s = 5'b11101;
            4'hE: s = 5'b11110;
            default: s = 5'b11111;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/nib_symbol_map.sv
// Combinational map from a tagged nibble to its 5-bit symbol.
// Assumes the tag overrides the nibble value when set.
module nib_symbol_map
    import tx4b5b_pkg::*;
(
    input  nib_t nibble,
    input  logic is_esc,
    output sym_t symbol
);
    // Select the escape code or the data code.
    always_comb begin
        if (is_esc) symbol = ESC_SYM;
        else        symbol = data_symbol(nibble);
    end
endmodule

// File: rtl/sym_serializer.sv
// Shifts one symbol out MSB first, one bit per clock.
// Assumes load is asserted only when idle or on the last bit.
module sym_serializer
    import tx4b5b_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  sym_t load_sym,
    output logic active,
    output logic last_bit,
    output logic cur_bit
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SYM_W - 1);

    sym_t             shreg;
    logic [CNT_W-1:0] bit_idx;

    // Load a new symbol, or shift and count the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
            active  <= 1'b0;
        end else if (load) begin
            shreg   <= load_sym;
            bit_idx <= '0;
            active  <= 1'b1;
        end else if (active) begin
            shreg <= {shreg[SYM_W-2:0], 1'b0};
            if (bit_idx == LAST_IDX) active <= 1'b0;
            else                     bit_idx <= bit_idx + 1'b1;
        end
    end

    // Expose the bit on the wire and the end-of-symbol marker.
    always_comb begin
        cur_bit  = shreg[SYM_W-1];
        last_bit = active && (bit_idx == LAST_IDX);
    end
endmodule

// File: rtl/nrzi_line.sv
// NRZI register: a 1 bit inverts the level, a 0 bit holds it.
// Assumes bit_in is meaningful only while shift_en is high.
module nrzi_line (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    output logic line
);
    // Update the line level once per transmitted bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        line <= 1'b0;
        else if (shift_en) line <= line ^ bit_in;
    end
endmodule

// File: rtl/nrzi_4b5b_tx.sv
// Top level: handshake, symbol map, serializer, NRZI line and underrun flag.
// Assumes the source offers a nibble every five clocks for a gap-free line.
module nrzi_4b5b_tx
    import tx4b5b_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [NIB_W-1:0] in_nibble,
    input  logic             in_is_esc,
    output logic             line_out,
    output logic             underrun_err
);
    sym_t next_sym;
    logic sym_active;
    logic last_bit;
    logic cur_bit;
    logic accept;

    // Handshake: take a nibble when idle or on a symbol's final bit.
    always_comb begin
        in_ready = !sym_active || last_bit;
        accept   = in_valid && in_ready;
    end

    nib_symbol_map u_map (
        .nibble (in_nibble),
        .is_esc (in_is_esc),
        .symbol (next_sym)
    );

    sym_serializer u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_sym (next_sym),
        .active   (sym_active),
        .last_bit (last_bit),
        .cur_bit  (cur_bit)
    );

    nrzi_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sym_active),
        .bit_in   (cur_bit),
        .line     (line_out)
    );

    // Flag a symbol boundary reached with nothing to send.
    always_ff @(posedge clk) begin
        if (!rst_n) underrun_err <= 1'b0;
        else        underrun_err <= last_bit && !in_valid;
    end
endmodule

// File: rtl/nrzi_4b5b_tx_chk.sv
// Checker bound to the top: temporal rules on handshake, line and flag.
module nrzi_4b5b_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic line_out,
    input logic underrun_err,
    input logic sym_active,
    input logic last_bit
);
    AST_IDLE_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_active |=> $stable(line_out)); // R5

    AST_READY_LOW_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R6

    AST_ERR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_err |=> !underrun_err); // R7

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_err |-> $past(last_bit && !in_valid)); // R7
endmodule

bind nrzi_4b5b_tx nrzi_4b5b_tx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .line_out     (line_out),
    .underrun_err (underrun_err),
    .sym_active   (sym_active),
    .last_bit     (last_bit)
);

// File: tb/tb_nrzi_4b5b_tx.sv
module tb_nrzi_4b5b_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_nibble = 4'h0;
    logic       in_is_esc = 1'b0;
    logic       in_ready;
    logic       line_out;
    logic       underrun_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nrzi_4b5b_tx dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_nibble(in_nibble), .in_is_esc(in_is_esc),
        .line_out(line_out), .underrun_err(underrun_err)
    );

    function automatic logic [4:0] ref_sym(input logic [3:0] n, input logic esc);
        logic [4:0] t [16] = '{5'b10101, 5'b01001, 5'b01010, 5'b01011,
                               5'b00111, 5'b01101, 5'b01110, 5'b01111,
                               5'b10010, 5'b11001, 5'b11010, 5'b11011,
                               5'b10111, 5'b11101, 5'b11110, 5'b11111};
        return esc ? 5'b00010 : t[n];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: a queue of pending line bits.
    bit         m_q[$];
    bit         m_line, m_err, m_popped, m_bit;
    logic [4:0] sym_q[$];
    bit         esc_q[$];
    int         m_run = 0, max_run = 0;

    always @(posedge clk) begin
        bit r, was_last;
        if (!rst_n) begin
            m_q.delete(); m_line = 0; m_err = 0; m_popped = 0;
        end else begin
            r = (m_q.size() <= 1);
            was_last = (m_q.size() == 1);
            m_err = 0; m_popped = 0;
            if (m_q.size() > 0) begin
                m_bit = m_q.pop_front();
                m_line ^= m_bit;
                m_popped = 1;
            end
            if (in_valid && r) begin
                logic [4:0] s;
                s = ref_sym(in_nibble, in_is_esc);
                for (int i = 4; i >= 0; i--) m_q.push_back(s[i]);
                sym_q.push_back(s);
                esc_q.push_back(in_is_esc);
            end else if (was_last) m_err = 1;
        end
    end

    // Per-cycle comparison and symbol recovery from line transitions.
    logic       prev_line = 1'b0;
    logic [4:0] rx_sym = '0;
    int         rx_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(line_out == m_line, "R5 line level", line_out, m_line);
            check(in_ready == (m_q.size() <= 1), "R6 ready", in_ready, m_q.size() <= 1);
            check(underrun_err == m_err, "R7 underrun flag", underrun_err, m_err);
            if (m_popped) begin
                rx_sym = {rx_sym[3:0], line_out ^ prev_line};
                rx_cnt++;
                if (line_out == prev_line) m_run++; else m_run = 1;
                if (m_run > max_run) max_run = m_run;
                if (rx_cnt == 5) begin
                    logic [4:0] e;
                    bit isesc;
                    e = sym_q.pop_front();
                    isesc = esc_q.pop_front();
                    check(rx_sym == e, isesc ? "R3 escape symbol R4" : "R2 data symbol R4",
                          rx_sym, e);
                    rx_cnt = 0;
                end
            end else m_run = 0;
        end
        prev_line = line_out;
    end

    task automatic send(input logic [3:0] n, input logic esc);
        @(negedge clk);
        in_valid = 1; in_nibble = n; in_is_esc = esc;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 0; in_nibble = 4'h5; in_is_esc = 1;
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(line_out == 0 && in_ready == 1 && underrun_err == 0, "R1 reset state",
              {line_out, in_ready, underrun_err}, 3'b010);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check(line_out == 0 && in_ready == 1 && underrun_err == 0, "R1 after release",
              {line_out, in_ready, underrun_err}, 3'b010);
        idle(4);
        // R2/R6: all data nibbles back to back.
        for (int i = 0; i < 16; i++) send(i[3:0], 1'b0);
        // R3: escapes with various nibble values, then escape-heavy runs for R8.
        send(4'h0, 1'b1); send(4'hF, 1'b1); send(4'h8, 1'b0); send(4'h8, 1'b1);
        send(4'h4, 1'b0); send(4'hA, 1'b1);
        idle(12);            // R7 underrun then long idle
        send(4'hC, 1'b0);
        idle(3);             // R7 gap of under one symbol
        send(4'h1, 1'b0); send(4'hE, 1'b0);
        for (int k = 0; k < 40; k++) begin
            send(4'((k * 7) % 16), (k % 5) == 0);
            if (k % 9 == 8) idle(k % 4 + 1);
        end
        idle(20);
        check(max_run <= 5, "R8 max run length", max_run, 5);
        check(sym_q.size() == 0, "R4 all symbols seen", sym_q.size(), 0);
        finish_run();
    end
endmodule